// File: doc/BRIEF.md
# Controller FIFO Pair with Event Interrupts

This block sits between software and the byte engine of a two-wire serial bus controller. Software writes transmit bytes into a 64-entry transmit queue through a 32-bit register port. Each byte can carry an end-of-transfer marker. The bus engine drains the queue through a pop handshake. In the other direction, the engine pushes received bytes into a 64-entry receive queue. Software reads them back one word per access. Each read returns a status code, so software never stalls on an empty queue. A single-cycle control write can flush either queue.

Four level-type events are collected in a status register: receive overflow, receive threshold reached, end of a transfer, and transmit underrun. Writing a one to a status bit clears it. An enable register with the same bit layout gates these events onto one interrupt line. Registers are selected by a 3-bit word index: 0 control, 1 enable, 2 status, 3 transmit, 4 receive.

Top module: `ctl_fifo_pair`

## Requirements
- R1: After reset, the control, enable and status registers all read zero, `irq_o` is low and `eng_tx_valid_o` is low.
- R2: A write to the transmit register queues `wdata[7:0]` with `wdata[31]` as the end marker. The engine sees entries in write order on `eng_tx_data_o`/`eng_tx_last_o`, qualified by `eng_tx_valid_o`.
- R3: A transmit write while 64 entries are queued is dropped and the queue contents are unchanged.
- R4: A read of the receive register returns status `2'b01` in bits 31:30 and the oldest byte in bits 7:0, and consumes that entry. If the queue is empty, the read returns status `2'b00` and consumes nothing.
- R5: Control bits 22:16 report the receive occupancy. An engine push while 64 entries are held is dropped and sets status bit 31.
- R6: Status bit 30 is set in every cycle where the threshold (control bits 13:8, written by any control write) is nonzero and occupancy is at or above it.
- R7: Status bit 27 is set in every cycle where the transmit queue is empty and `eng_tx_need_i` is high.
- R8: Status bit 28 is set the cycle after `eng_busy_i` falls from 1 to 0.
- R9: A status bit stays set until software writes a one to it. Writing zeros leaves it unchanged, whatever the enable. If an event and a clear happen in the same cycle, the event wins.
- R10: `irq_o` is high exactly when some status bit is set and its enable bit (same position) is set.
- R11: A control write with bit 31 set empties the receive queue. With bit 30 set, it empties the transmit queue. Both flush bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the access cycle |
| eng_tx_pop_i | input | 1 | Engine takes the head transmit entry |
| eng_tx_valid_o | output | 1 | Transmit queue not empty |
| eng_tx_data_o | output | 8 | Head transmit byte |
| eng_tx_last_o | output | 1 | End marker of head entry |
| eng_tx_need_i | input | 1 | Engine still expects transmit bytes |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| eng_busy_i | input | 1 | Engine transfer in progress |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench fills the transmit queue one entry past capacity and then drains it. A design that accepted the extra word would overwrite the oldest entry or lose the end marker. The bench also drives 65 receive pushes. A design that failed to flag the overflow, or that wrapped the occupancy, would show a wrong count or a clear bit 31. The threshold is checked one byte below and at the programmed level; an off-by-one compare fires early or late. The status register is tested with a clear while the enable is low, a partial clear that must not touch other bits, and an empty receive read. That read must neither stall nor move the occupancy.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_IEN  = 3'd1,
    REG_IST  = 3'd2,
    REG_TXD  = 3'd3,
    REG_RXD  = 3'd4
  } reg_sel_e;

  localparam int CTL_RX_FLUSH = 31;
  localparam int CTL_TX_FLUSH = 30;
  localparam int CTL_CNT_LSB  = 16;
  localparam int CTL_THLD_LSB = 8;

  localparam int EV_RX_FULL = 31;
  localparam int EV_RX_THLD = 30;
  localparam int EV_DONE    = 28;
  localparam int EV_TX_UNDR = 27;

  localparam logic [31:0] EV_MASK = (32'd1 << EV_RX_FULL) | (32'd1 << EV_RX_THLD)
                                  | (32'd1 << EV_DONE)    | (32'd1 << EV_TX_UNDR);

  localparam int TXD_LAST_BIT = 31;
  localparam int RXD_STAT_LSB = 30;
  localparam logic [1:0] RXS_EMPTY = 2'b00;
  localparam logic [1:0] RXS_DATA  = 2'b01;
endpackage

// File: rtl/pair_sfifo.sv
module pair_sfifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/pair_irq_regs.sv
module pair_irq_regs
  import fifo_pair_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] set_i,
  input  logic [31:0] clr_i,
  input  logic        ien_we_i,
  input  logic [31:0] ien_wdata_i,
  output logic [31:0] ien_o,
  output logic [31:0] ist_o,
  output logic        irq_o
);
  logic [31:0] ien_q, ist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= ien_wdata_i & EV_MASK;
      // set takes priority over a same-cycle clear
      ist_q <= ((ist_q & ~clr_i) | set_i) & EV_MASK;
    end
  end

  assign ien_o = ien_q;
  assign ist_o = ist_q;
  assign irq_o = |(ist_q & ien_q);
endmodule

// File: rtl/ctl_fifo_pair.sv
module ctl_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int THLD_W = 6,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_valid_i,
  input  logic        reg_write_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        eng_tx_pop_i,
  output logic        eng_tx_valid_o,
  output logic [7:0]  eng_tx_data_o,
  output logic        eng_tx_last_o,
  input  logic        eng_tx_need_i,
  input  logic        eng_rx_push_i,
  input  logic [7:0]  eng_rx_data_i,
  input  logic        eng_busy_i,
  output logic        irq_o
);
  reg_sel_e             sel;
  logic                 wr, rd;
  logic                 ctrl_wr, rx_flush, tx_flush, tx_push, rx_rd;
  logic [THLD_W-1:0]    thld_q;
  logic [DATA_W:0]      tx_head;
  logic                 tx_empty, rx_empty, rx_full, rx_drop;
  logic [CW-1:0]        tx_cnt, rx_cnt;
  logic [DATA_W-1:0]    rx_head;
  logic                 busy_q;
  logic [31:0]          ev_set, ist_clr, ien, ist;

  assign sel      = reg_sel_e'(reg_addr_i);
  assign wr       = reg_valid_i && reg_write_i;
  assign rd       = reg_valid_i && !reg_write_i;
  assign ctrl_wr  = wr && (sel == REG_CTRL);
  assign rx_flush = ctrl_wr && reg_wdata_i[CTL_RX_FLUSH];
  assign tx_flush = ctrl_wr && reg_wdata_i[CTL_TX_FLUSH];
  assign tx_push  = wr && (sel == REG_TXD);
  assign rx_rd    = rd && (sel == REG_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thld_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (ctrl_wr) thld_q <= reg_wdata_i[CTL_THLD_LSB +: THLD_W];
      busy_q <= eng_busy_i;
    end
  end

  pair_sfifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush),
    .push_i  (tx_push),
    .wdata_i ({reg_wdata_i[TXD_LAST_BIT], reg_wdata_i[DATA_W-1:0]}),
    .pop_i   (eng_tx_pop_i),
    .rdata_o (tx_head),
    .empty_o (tx_empty),
    .cnt_o   (tx_cnt)
  );

  pair_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rx_rd),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .cnt_o   (rx_cnt)
  );

  assign eng_tx_valid_o = !tx_empty;
  assign eng_tx_data_o  = tx_head[DATA_W-1:0];
  assign eng_tx_last_o  = tx_head[DATA_W];

  assign rx_full = (rx_cnt == CW'(DEPTH));
  assign rx_drop = eng_rx_push_i && rx_full && !rx_flush;

  always_comb begin
    ev_set             = '0;
    ev_set[EV_RX_FULL] = rx_drop;
    ev_set[EV_RX_THLD] = (thld_q != '0) && (rx_cnt >= CW'(thld_q));
    ev_set[EV_DONE]    = busy_q && !eng_busy_i;
    ev_set[EV_TX_UNDR] = tx_empty && eng_tx_need_i;
  end

  assign ist_clr = (wr && (sel == REG_IST)) ? reg_wdata_i : '0;

  pair_irq_regs u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (ev_set),
    .clr_i       (ist_clr),
    .ien_we_i    (wr && (sel == REG_IEN)),
    .ien_wdata_i (reg_wdata_i),
    .ien_o       (ien),
    .ist_o       (ist),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      REG_CTRL: begin
        reg_rdata_o[CTL_CNT_LSB +: CW]      = rx_cnt;
        reg_rdata_o[CTL_THLD_LSB +: THLD_W] = thld_q;
      end
      REG_IEN: reg_rdata_o = ien;
      REG_IST: reg_rdata_o = ist;
      REG_RXD: begin
        reg_rdata_o[RXD_STAT_LSB +: 2] = rx_empty ? RXS_EMPTY : RXS_DATA;
        reg_rdata_o[DATA_W-1:0]        = rx_empty ? '0 : rx_head;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ctl_fifo_pair_chk.sv
module ctl_fifo_pair_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          eng_busy_i,
  input logic          eng_tx_pop_i,
  input logic          irq_o,
  input logic [31:0]   reg_rdata_o,
  input logic [31:0]   ist,
  input logic [31:0]   ien,
  input logic [31:0]   ist_clr,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          rx_rd
);
  AST_RX_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(DEPTH)); // R5
  AST_TX_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt == CW'(DEPTH) && !eng_tx_pop_i && !tx_flush) |=> tx_cnt == CW'(DEPTH)); // R3
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && rx_cnt == '0) |-> reg_rdata_o[31:30] == 2'b00); // R4
  AST_DONE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eng_busy_i) |=> ist[28]); // R8
  AST_STICKY_UNDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ist[27] && !ist_clr[27]) |=> ist[27]); // R9
  AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == '0) |-> !irq_o); // R10
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush |=> rx_cnt == '0); // R11
endmodule

bind ctl_fifo_pair ctl_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .eng_busy_i   (eng_busy_i),
  .eng_tx_pop_i (eng_tx_pop_i),
  .irq_o        (irq_o),
  .reg_rdata_o  (reg_rdata_o),
  .ist          (ist),
  .ien          (ien),
  .ist_clr      (ist_clr),
  .rx_cnt       (rx_cnt),
  .tx_cnt       (tx_cnt),
  .tx_flush     (tx_flush),
  .rx_flush     (rx_flush),
  .rx_rd        (rx_rd)
);

// File: tb/ctl_fifo_pair_bench.sv
`timescale 1ns/1ps
module ctl_fifo_pair_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0, reg_write_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        eng_tx_pop_i = 1'b0, eng_tx_valid_o, eng_tx_last_o;
  logic [7:0]  eng_tx_data_o;
  logic        eng_tx_need_i = 1'b0, eng_rx_push_i = 1'b0, eng_busy_i = 1'b0;
  logic [7:0]  eng_rx_data_i = '0;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  logic [8:0] tx_exp[$];
  logic [7:0] rx_exp[$];
  logic [31:0] rv;

  always #5 clk_i = ~clk_i;

  ctl_fifo_pair u_ctl_fifo_pair (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FIFO-PAIR FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(posedge clk_i); #1;
    reg_valid_i = 1'b0;
  endtask

  // driver: queue expected transmit entry when the queue has room
  task automatic tx_write(input logic last, input logic [7:0] b, input bit expect_keep);
    if (expect_keep) tx_exp.push_back({last, b});
    reg_wr(3'd3, {last, 23'd0, b});
  endtask

  task automatic eng_pop();
    @(negedge clk_i);
    eng_tx_pop_i = 1'b1;
    @(posedge clk_i); #1;
    eng_tx_pop_i = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b, input bit expect_keep);
    if (expect_keep) rx_exp.push_back(b);
    @(negedge clk_i);
    eng_rx_push_i = 1'b1; eng_rx_data_i = b;
    @(posedge clk_i); #1;
    eng_rx_push_i = 1'b0;
  endtask

  task automatic rx_read_chk();
    logic [7:0] e;
    reg_rd(3'd4, rv);
    if (rx_exp.size() == 0) begin
      chk(rv[31:30] == 2'b00, "R4 empty status", rv, 32'h0);
    end else begin
      e = rx_exp.pop_front();
      chk(rv[31:30] == 2'b01 && rv[7:0] == e, "R4 rx data", rv, {2'b01, 22'd0, e});
    end
  endtask

  // monitor: compare engine pops against the scoreboard
  always @(negedge clk_i) begin
    #3;
    if (eng_tx_pop_i && eng_tx_valid_o) begin
      if (tx_exp.size() == 0)
        chk(1'b0, "R2 unexpected tx", {23'd0, eng_tx_last_o, eng_tx_data_o}, 32'h0);
      else begin
        logic [8:0] e;
        e = tx_exp.pop_front();
        chk({eng_tx_last_o, eng_tx_data_o} == e, "R2 tx order/marker",
            {23'd0, eng_tx_last_o, eng_tx_data_o}, {23'd0, e});
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FIFO-PAIR FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    reg_rd(3'd0, rv); chk(rv == 0, "R1 ctrl", rv, 0);
    reg_rd(3'd1, rv); chk(rv == 0, "R1 ien", rv, 0);
    reg_rd(3'd2, rv); chk(rv == 0, "R1 ist", rv, 0);
    chk(!irq_o && !eng_tx_valid_o, "R1 outputs", {30'd0, irq_o, eng_tx_valid_o}, 0);

    // R2 short transfer with marker
    tx_write(1'b0, 8'hA1, 1'b1);
    tx_write(1'b0, 8'h5C, 1'b1);
    tx_write(1'b1, 8'h07, 1'b1);
    #1 chk(eng_tx_valid_o, "R2 valid", {31'd0, eng_tx_valid_o}, 1);
    repeat (3) eng_pop();
    chk(!eng_tx_valid_o && tx_exp.size() == 0, "R2 drained", {31'd0, eng_tx_valid_o}, 0);

    // R3 fill past capacity
    for (int i = 0; i < 65; i++) tx_write(i == 64, 8'(i * 3 + 1), i < 64);
    for (int i = 0; i < 64; i++) eng_pop();
    chk(!eng_tx_valid_o && tx_exp.size() == 0, "R3 extra dropped", {31'd0, eng_tx_valid_o}, 0);

    // R7/R9/R10 underrun sticky with enable low
    eng_tx_need_i = 1'b1;
    repeat (2) @(posedge clk_i); #1;
    reg_rd(3'd2, rv); chk(rv[27], "R7 underrun set", rv, 32'h0800_0000);
    chk(!irq_o, "R10 masked", {31'd0, irq_o}, 0);
    eng_tx_need_i = 1'b0;
    reg_wr(3'd2, 32'h4000_0000);
    reg_rd(3'd2, rv); chk(rv == 32'h0800_0000, "R9 partial clear", rv, 32'h0800_0000);
    reg_wr(3'd1, 32'h0800_0000);
    #1 chk(irq_o, "R10 enabled irq", {31'd0, irq_o}, 1);
    reg_wr(3'd2, 32'h0800_0000);
    reg_rd(3'd2, rv); chk(rv == 0, "R9 w1c", rv, 0);
    chk(!irq_o, "R10 irq cleared", {31'd0, irq_o}, 0);

    // R6 threshold
    reg_wr(3'd0, 32'h0000_0600);
    for (int i = 0; i < 5; i++) eng_push(8'(8'h40 + i), 1'b1);
    repeat (2) @(posedge clk_i); #1;
    reg_rd(3'd2, rv); chk(!rv[30], "R6 below thld", rv, 0);
    reg_rd(3'd0, rv); chk(rv[22:16] == 5 && rv[13:8] == 6, "R5 count", rv, 32'h0005_0600);
    eng_push(8'h45, 1'b1);
    repeat (2) @(posedge clk_i); #1;
    reg_rd(3'd2, rv); chk(rv[30], "R6 at thld", rv, 32'h4000_0000);

    // R4 read order and empty read
    for (int i = 0; i < 6; i++) rx_read_chk();
    rx_read_chk();
    reg_rd(3'd0, rv); chk(rv[22:16] == 0, "R4 empty read no consume", rv, 32'h0000_0600);

    // R5 overflow
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd2, 32'hFFFF_FFFF);
    for (int i = 0; i < 65; i++) eng_push(8'(i), i < 64);
    reg_rd(3'd0, rv); chk(rv[22:16] == 64, "R5 full count", rv, 32'h0040_0000);
    reg_rd(3'd2, rv); chk(rv[31], "R5 overflow flag", rv, 32'h8000_0000);
    rx_read_chk(); rx_read_chk();

    // R11 flushes
    reg_wr(3'd0, 32'h8000_0000);
    rx_exp.delete();
    reg_rd(3'd0, rv); chk(rv == 0, "R11 rx flush", rv, 0);
    rx_read_chk();
    reg_wr(3'd3, 32'h0000_0011);
    reg_wr(3'd3, 32'h0000_0022);
    reg_wr(3'd0, 32'h4000_0000);
    #1 chk(!eng_tx_valid_o, "R11 tx flush", {31'd0, eng_tx_valid_o}, 0);

    // R8 transfer done
    reg_wr(3'd2, 32'hFFFF_FFFF);
    reg_wr(3'd1, 32'h1000_0000);
    @(negedge clk_i) eng_busy_i = 1'b1;
    repeat (3) @(negedge clk_i);
    reg_rd(3'd2, rv); chk(!rv[28], "R8 not while busy", rv, 0);
    eng_busy_i = 1'b0;
    repeat (2) @(posedge clk_i); #1;
    reg_rd(3'd2, rv); chk(rv[28], "R8 done set", rv, 32'h1000_0000);
    chk(irq_o, "R10 done irq", {31'd0, irq_o}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule